// File: doc/BRIEF.md
# MDIO Board Control Register File

This block is the slave end of a two-wire management link. An external master clocks it with MDC and moves serial data over a shared MDIO line; the block decodes the frames, keeps a small set of board control registers, and drives the line only while it returns read data. The block runs on its own system clock. MDC and incoming MDIO are synchronized into that domain, and the rising and falling edges of MDC are detected there.

The two 5-bit address fields of a frame are taken together as one 10-bit register address, so the block spans far more than 32 registers. Low addresses hold identification words, strap and switch inputs, and writable mode, power, peripheral and LED settings, which appear on output pins. A write to the reset register starts a fixed-length board reset pulse. Four high addresses stand for a slow non-volatile area: each read there returns whatever the previous read of that area fetched, so software reads twice and keeps the second value.

The link is a shared serial line with no back-pressure. No valid/ready interface is used: the master sets the pace, and the block must keep up with every MDC edge.

Top module: `mdio_regfile`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones, then start bits 0 then 1, then an opcode of 10 (read) or 01 (write). Any other opcode, a bad second start bit, or a shorter run of ones makes the frame have no effect.
- R2: The register address is the first 5-bit field times 32 plus the second 5-bit field. Both fields and the 16-bit data word are sent most significant bit first.
- R3: On a read the block leaves MDIO undriven (mdio_oe=0) for the first turnaround bit and drives 0 for the second. It then drives the 16 data bits, each changed only after an MDC falling edge, and releases the line after the last bit.
- R4: Writes are stored at 0x004, 0x005, 0x00A, 0x00B, 0x00C, 0x00D and 0x00E and read back unchanged. mode_cfg is {0x005,0x004}, power_cfg is 0x00B, peri_cfg is {0x00D,0x00C} and led_cfg is 0x00E. These outputs change only through such writes.
- R5: 0x000 to 0x003 return the identification parameters (defaults 0x3A51, 0x0007, 0x0210, 0x0019). 0x006 and 0x007 return the low and high halves of strap_mode, and 0x008 returns dip_sw. Writes to any of these have no effect.
- R6: A read of any address not listed in R4, R5 or R8 returns 0xFFFF. Writes to those addresses have no effect.
- R7: Writing the value 1 to 0x00A holds board_rst high for exactly 16 system clocks, after which 0x00A reads 0. Writing any other value stores it and gives no pulse.
- R8: A read of 0x300 to 0x303 returns the value fetched by the previous read in that range, which is 0 after reset. The contents are, in order, the board revision 0x0103, the SoC revision 0x0302, and the serial number low half 0xD2E1 then high half 0x0004. Two back-to-back reads of one address return the correct value on the second.
- R9: After reset all configuration outputs, mdio_oe and board_rst are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock from the master |
| mdio_i | input | 1 | MDIO line as seen at the pin |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | Output enable for the MDIO driver |
| strap_mode | input | 32 | Applied mode straps, readable at 0x006/0x007 |
| dip_sw | input | 16 | Switch inputs, readable at 0x008 |
| mode_cfg | output | 32 | Mode setting registers |
| power_cfg | output | 16 | Power configuration register |
| peri_cfg | output | 32 | Peripheral configuration registers |
| led_cfg | output | 16 | LED register |
| board_rst | output | 1 | Board reset pulse |

## Verification
On every cycle the assertions check four things. The first bit the block drives is a turnaround zero. The output enable moves only after a detected MDC falling edge. board_rst never stays high longer than 16 clocks and always falls after exactly 16. The LED and power outputs change only after a decoded write. The bench's scenarios are needed for the rest, because each depends on a whole frame or on a history of accesses: rejecting frames with a short preamble, bad start bits or a bad opcode, joining the two address fields, ignoring writes to read-only and unmapped addresses, and the stale first read in the high range.

// File: rtl/mdio_rf_pkg.sv
package mdio_rf_pkg;
  typedef enum logic [2:0] {
    FS_PRE, FS_START, FS_OP, FS_ADDR, FS_TURN, FS_DATA
  } frame_st_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_i,
  output logic mdio_s,
  output logic mdc_rise,
  output logic mdc_fall
);
  logic [STAGES-1:0] mdc_q;
  logic [STAGES-1:0] dat_q;
  logic              mdc_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q    <= '0;
      dat_q    <= '0;
      mdc_last <= 1'b0;
    end else begin
      mdc_q    <= {mdc_q[STAGES-2:0], mdc};
      dat_q    <= {dat_q[STAGES-2:0], mdio_i};
      mdc_last <= mdc_q[STAGES-1];
    end
  end

  // data passes the same number of stages as the clock, so they stay aligned
  assign mdio_s   = dat_q[STAGES-1];
  assign mdc_rise = mdc_q[STAGES-1] & ~mdc_last;
  assign mdc_fall = ~mdc_q[STAGES-1] & mdc_last;
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_rf_pkg::*;
#(
  parameter int AW      = 10,
  parameter int DW      = 16,
  parameter int PRE_LEN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          fall,
  input  logic          bit_i,
  input  logic [DW-1:0] rd_data,
  output logic          rd_req,
  output logic          wr_en,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wr_data,
  output logic          mdio_o,
  output logic          mdio_oe
);
  localparam int CW = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0] PRE_MAX  = CW'(PRE_LEN);
  localparam logic [CW-1:0] ADDR_END = CW'(AW - 1);
  localparam logic [CW-1:0] DATA_END = CW'(DW - 1);

  frame_st_e     st;
  logic [CW-1:0] cnt;
  logic          op_hi;
  logic          is_rd;
  logic [DW-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= FS_PRE;
      cnt     <= '0;
      op_hi   <= 1'b0;
      is_rd   <= 1'b0;
      addr    <= '0;
      wr_data <= '0;
      rd_req  <= 1'b0;
      wr_en   <= 1'b0;
    end else begin
      rd_req <= 1'b0;
      wr_en  <= 1'b0;
      if (rise) begin
        case (st)
          FS_PRE: begin
            if (bit_i) begin
              if (cnt != PRE_MAX) cnt <= cnt + 1'b1;
            end else if (cnt == PRE_MAX) begin
              st  <= FS_START;
              cnt <= '0;
            end else begin
              cnt <= '0;
            end
          end
          FS_START: begin
            st  <= bit_i ? FS_OP : FS_PRE;
            cnt <= '0;
          end
          FS_OP: begin
            if (cnt == '0) begin
              op_hi <= bit_i;
              cnt   <= 1;
            end else begin
              cnt <= '0;
              if ({op_hi, bit_i} == OP_RD) begin
                is_rd <= 1'b1;
                st    <= FS_ADDR;
              end else if ({op_hi, bit_i} == OP_WR) begin
                is_rd <= 1'b0;
                st    <= FS_ADDR;
              end else begin
                st <= FS_PRE;
              end
            end
          end
          FS_ADDR: begin
            addr <= {addr[AW-2:0], bit_i};
            if (cnt == ADDR_END) begin
              st     <= FS_TURN;
              cnt    <= '0;
              rd_req <= is_rd;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FS_TURN: begin
            if (cnt == '0) cnt <= 1;
            else begin
              st  <= FS_DATA;
              cnt <= '0;
            end
          end
          default: begin
            wr_data <= {wr_data[DW-2:0], bit_i};
            if (cnt == DATA_END) begin
              st    <= FS_PRE;
              cnt   <= '0;
              wr_en <= ~is_rd;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  // output side: changes only on a falling MDC edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      if (rd_req) tx_sh <= rd_data;
      if (fall) begin
        if (is_rd && st == FS_TURN && cnt != '0) begin
          mdio_oe <= 1'b1;
          mdio_o  <= 1'b0;
        end else if (is_rd && st == FS_DATA) begin
          mdio_oe <= 1'b1;
          mdio_o  <= tx_sh[DW-1];
          tx_sh   <= {tx_sh[DW-2:0], 1'b0};
        end else begin
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_rf_regs.sv
module mdio_rf_regs #(
  parameter int              AW        = 10,
  parameter int              DW        = 16,
  parameter int              RST_CYC   = 16,
  parameter logic [DW-1:0]   ID_PROD_LO = 16'h3A51,
  parameter logic [DW-1:0]   ID_PROD_HI = 16'h0007,
  parameter logic [DW-1:0]   ID_VER_LO  = 16'h0210,
  parameter logic [DW-1:0]   ID_VER_HI  = 16'h0019,
  parameter logic [DW-1:0]   NV_BOARD   = 16'h0103,
  parameter logic [DW-1:0]   NV_SOC     = 16'h0302,
  parameter logic [2*DW-1:0] NV_SERIAL  = 32'h0004_D2E1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_req,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [2*DW-1:0] strap_mode,
  input  logic [DW-1:0]   dip_sw,
  output logic [DW-1:0]   rd_data,
  output logic [2*DW-1:0] mode_cfg,
  output logic [DW-1:0]   power_cfg,
  output logic [2*DW-1:0] peri_cfg,
  output logic [DW-1:0]   led_cfg,
  output logic            board_rst
);
  localparam logic [AW-1:0] A_MODE_LO = AW'('h004);
  localparam logic [AW-1:0] A_MODE_HI = AW'('h005);
  localparam logic [AW-1:0] A_RST     = AW'('h00A);
  localparam logic [AW-1:0] A_PWR     = AW'('h00B);
  localparam logic [AW-1:0] A_PERI_LO = AW'('h00C);
  localparam logic [AW-1:0] A_PERI_HI = AW'('h00D);
  localparam logic [AW-1:0] A_LED     = AW'('h00E);
  localparam logic [AW-1:0] NV_BASE   = AW'('h300);
  localparam int            TW        = $clog2(RST_CYC + 1);

  logic [DW-1:0] rst_reg;
  logic [DW-1:0] nv_q;
  logic [TW-1:0] rst_cnt;
  logic          nv_sel;

  assign nv_sel = (addr[AW-1:2] == NV_BASE[AW-1:2]);

  function automatic logic [DW-1:0] nv_word(input logic [1:0] idx);
    case (idx)
      2'd0:    return NV_BOARD;
      2'd1:    return NV_SOC;
      2'd2:    return NV_SERIAL[DW-1:0];
      default: return NV_SERIAL[2*DW-1:DW];
    endcase
  endfunction

  always_comb begin
    rd_data = '1;
    if (nv_sel) rd_data = nv_q;
    else begin
      case (addr)
        AW'('h000): rd_data = ID_PROD_LO;
        AW'('h001): rd_data = ID_PROD_HI;
        AW'('h002): rd_data = ID_VER_LO;
        AW'('h003): rd_data = ID_VER_HI;
        A_MODE_LO:  rd_data = mode_cfg[DW-1:0];
        A_MODE_HI:  rd_data = mode_cfg[2*DW-1:DW];
        AW'('h006): rd_data = strap_mode[DW-1:0];
        AW'('h007): rd_data = strap_mode[2*DW-1:DW];
        AW'('h008): rd_data = dip_sw;
        A_RST:      rd_data = rst_reg;
        A_PWR:      rd_data = power_cfg;
        A_PERI_LO:  rd_data = peri_cfg[DW-1:0];
        A_PERI_HI:  rd_data = peri_cfg[2*DW-1:DW];
        A_LED:      rd_data = led_cfg;
        default:    rd_data = '1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_cfg  <= '0;
      power_cfg <= '0;
      peri_cfg  <= '0;
      led_cfg   <= '0;
      rst_reg   <= '0;
      rst_cnt   <= '0;
      nv_q      <= '0;
    end else begin
      // slow area: hand back the previous fetch, start the next one
      if (rd_req && nv_sel) nv_q <= nv_word(addr[1:0]);
      if (rst_cnt != '0) begin
        rst_cnt <= rst_cnt - 1'b1;
        if (rst_cnt == TW'(1)) rst_reg <= '0;
      end
      if (wr_en) begin
        case (addr)
          A_MODE_LO: mode_cfg[DW-1:0]    <= wr_data;
          A_MODE_HI: mode_cfg[2*DW-1:DW] <= wr_data;
          A_PWR:     power_cfg           <= wr_data;
          A_PERI_LO: peri_cfg[DW-1:0]    <= wr_data;
          A_PERI_HI: peri_cfg[2*DW-1:DW] <= wr_data;
          A_LED:     led_cfg             <= wr_data;
          A_RST: begin
            rst_reg <= wr_data;
            if (wr_data == DW'(1)) rst_cnt <= TW'(RST_CYC);
          end
          default: ;
        endcase
      end
    end
  end

  assign board_rst = (rst_cnt != '0);
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile #(
  parameter int AW          = 10,
  parameter int DW          = 16,
  parameter int PRE_LEN     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYC     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mdc,
  input  logic            mdio_i,
  output logic            mdio_o,
  output logic            mdio_oe,
  input  logic [2*DW-1:0] strap_mode,
  input  logic [DW-1:0]   dip_sw,
  output logic [2*DW-1:0] mode_cfg,
  output logic [DW-1:0]   power_cfg,
  output logic [2*DW-1:0] peri_cfg,
  output logic [DW-1:0]   led_cfg,
  output logic            board_rst
);
  logic          mdio_s, mdc_rise, mdc_fall;
  logic          rd_req, wr_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data, rd_data;

  mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_s(mdio_s), .mdc_rise(mdc_rise), .mdc_fall(mdc_fall)
  );

  mdio_frame #(.AW(AW), .DW(DW), .PRE_LEN(PRE_LEN)) u_frame (
    .clk(clk), .rst_n(rst_n), .rise(mdc_rise), .fall(mdc_fall),
    .bit_i(mdio_s), .rd_data(rd_data), .rd_req(rd_req), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_rf_regs #(.AW(AW), .DW(DW), .RST_CYC(RST_CYC)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .strap_mode(strap_mode),
    .dip_sw(dip_sw), .rd_data(rd_data), .mode_cfg(mode_cfg),
    .power_cfg(power_cfg), .peri_cfg(peri_cfg), .led_cfg(led_cfg),
    .board_rst(board_rst)
  );
endmodule

// File: rtl/mdio_rf_checker.sv
module mdio_rf_checker #(
  parameter int DW      = 16,
  parameter int RST_CYC = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mdio_o,
  input logic          mdio_oe,
  input logic          board_rst,
  input logic          fall,
  input logic          wr_en,
  input logic [DW-1:0] led_cfg,
  input logic [DW-1:0] power_cfg
);
  localparam int HW = $clog2(RST_CYC + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else        hi_cnt <= board_rst ? hi_cnt + 1'b1 : '0;
  end

  // R3: the first driven bit is the turnaround zero
  p_ta_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> (mdio_o == 1'b0));

  // R3: the driver only switches after a falling MDC edge
  p_oe_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe != $past(mdio_oe)) |-> $past(fall));

  // R7: pulse never longer than the set length
  p_rst_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst |-> (hi_cnt < HW'(RST_CYC)));

  // R7: pulse ends only after the full length
  p_rst_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!board_rst && hi_cnt != '0) |-> (hi_cnt == HW'(RST_CYC)));

  // R4: configuration outputs move only after a decoded write
  p_led_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (led_cfg != $past(led_cfg)) |-> $past(wr_en));

  p_pwr_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (power_cfg != $past(power_cfg)) |-> $past(wr_en));
endmodule

bind mdio_regfile mdio_rf_checker #(.DW(DW), .RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .board_rst(board_rst), .fall(mdc_fall), .wr_en(wr_en),
  .led_cfg(led_cfg), .power_cfg(power_cfg)
);

// File: tb/mdio_regfile_tb.sv
module mdio_regfile_tb;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdc = 1'b0;
  logic        m_oe = 1'b0;
  logic        m_o = 1'b1;
  logic [31:0] strap_mode = 32'h1357_9BDF;
  logic [15:0] dip_sw = 16'h00A6;
  logic        dut_o, dut_oe, board_rst;
  logic [31:0] mode_cfg, peri_cfg;
  logic [15:0] power_cfg, led_cfg;
  wire         mdio_line;

  assign mdio_line = dut_oe ? dut_o : (m_oe ? m_o : 1'b1);

  always #4 clk = ~clk;

  mdio_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_line),
    .mdio_o(dut_o), .mdio_oe(dut_oe), .strap_mode(strap_mode),
    .dip_sw(dip_sw), .mode_cfg(mode_cfg), .power_cfg(power_cfg),
    .peri_cfg(peri_cfg), .led_cfg(led_cfg), .board_rst(board_rst)
  );

  // reference state
  int          n_tests = 0;
  int          n_fail = 0;
  logic [15:0] m_mode_lo = 0, m_mode_hi = 0, m_rst = 0, m_pwr = 0;
  logic [15:0] m_peri_lo = 0, m_peri_hi = 0, m_led = 0, nv_prev = 0;
  bit          quiet = 1'b1;
  bit          armed = 1'b0;
  int          hi_run = 0;
  int          pulses = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] nv_true(input logic [9:0] a);
    case (a[1:0])
      2'd0: return 16'h0103;
      2'd1: return 16'h0302;
      2'd2: return 16'hD2E1;
      default: return 16'h0004;
    endcase
  endfunction

  function automatic logic [15:0] exp_rd(input logic [9:0] a);
    if (a >= 10'h300 && a <= 10'h303) return nv_prev;
    case (a)
      10'h000: return 16'h3A51;
      10'h001: return 16'h0007;
      10'h002: return 16'h0210;
      10'h003: return 16'h0019;
      10'h004: return m_mode_lo;
      10'h005: return m_mode_hi;
      10'h006: return strap_mode[15:0];
      10'h007: return strap_mode[31:16];
      10'h008: return dip_sw;
      10'h00A: return m_rst;
      10'h00B: return m_pwr;
      10'h00C: return m_peri_lo;
      10'h00D: return m_peri_hi;
      10'h00E: return m_led;
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic apply_write(input logic [9:0] a, input logic [15:0] d);
    case (a)
      10'h004: m_mode_lo = d;
      10'h005: m_mode_hi = d;
      10'h00A: m_rst = (d == 16'd1) ? 16'd0 : d;
      10'h00B: m_pwr = d;
      10'h00C: m_peri_lo = d;
      10'h00D: m_peri_hi = d;
      10'h00E: m_led = d;
      default: ;
    endcase
  endtask

  // per-clock comparison of the mirrored outputs and the reset pulse
  always @(negedge clk) begin
    if (rst_n && !quiet) begin
      chk(led_cfg == m_led, "R4 led_cfg", {16'h0, led_cfg}, {16'h0, m_led});
      chk(power_cfg == m_pwr, "R4 power_cfg", {16'h0, power_cfg}, {16'h0, m_pwr});
      chk(mode_cfg == {m_mode_hi, m_mode_lo}, "R4 mode_cfg", mode_cfg, {m_mode_hi, m_mode_lo});
      chk(peri_cfg == {m_peri_hi, m_peri_lo}, "R4 peri_cfg", peri_cfg, {m_peri_hi, m_peri_lo});
    end
    if (rst_n) begin
      if (board_rst) begin
        if (hi_run == 0) chk(armed, "R7 pulse without request", 1, {31'h0, armed});
        hi_run++;
      end else if (hi_run != 0) begin
        chk(hi_run == 16, "R7 pulse width", hi_run, 16);
        hi_run = 0;
        armed = 1'b0;
        pulses++;
      end
    end
  end

  task automatic send_bit(input logic b);
    mdc = 1'b0;
    m_oe = 1'b1;
    m_o = b;
    repeat (HALF) @(negedge clk);
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic raw_frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                           input logic [9:0] a, input logic [15:0] d);
    bit valid;
    valid = (pre >= 32) && (st == 2'b01) && (op == 2'b01);
    for (int i = 0; i < pre; i++) send_bit(1'b1);
    send_bit(st[1]); send_bit(st[0]);
    send_bit(op[1]); send_bit(op[0]);
    for (int i = 9; i >= 0; i--) send_bit(a[i]);
    send_bit(1'b1); send_bit(1'b0);
    for (int i = 15; i >= 1; i--) send_bit(d[i]);
    quiet = 1'b1;
    if (valid && a == 10'h00A && d == 16'd1) armed = 1'b1;
    send_bit(d[0]);
    if (valid) apply_write(a, d);
    quiet = 1'b0;
    m_oe = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [15:0] d);
    raw_frame(32, 2'b01, 2'b01, a, d);
  endtask

  task automatic rd(input logic [9:0] a, input string tag);
    logic [15:0] exp, got;
    logic        ta;
    exp = exp_rd(a);
    got = '0;
    for (int i = 0; i < 32; i++) send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1);
    send_bit(1'b1); send_bit(1'b0);
    for (int i = 9; i >= 0; i--) send_bit(a[i]);
    m_oe = 1'b0;
    mdc = 1'b0;
    repeat (HALF) @(negedge clk);
    chk(dut_oe == 1'b0, "R3 line released in first turnaround bit", {31'h0, dut_oe}, 0);
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
    mdc = 1'b0;
    repeat (HALF) @(negedge clk);
    ta = mdio_line;
    chk(dut_oe && ta == 1'b0, "R3 second turnaround bit driven 0", {30'h0, dut_oe, ta}, 32'h2);
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 15; i >= 0; i--) begin
      mdc = 1'b0;
      repeat (HALF) @(negedge clk);
      got[i] = mdio_line;
      mdc = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    mdc = 1'b0;
    repeat (HALF) @(negedge clk);
    chk(dut_oe == 1'b0, "R3 line released after data", {31'h0, dut_oe}, 0);
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
    chk(got == exp, tag, {16'h0, got}, {16'h0, exp});
    if (a >= 10'h300 && a <= 10'h303) nv_prev = nv_true(a);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(led_cfg == 0 && power_cfg == 0, "R9 reset led/power", {led_cfg, power_cfg}, 0);
    chk(mode_cfg == 0 && peri_cfg == 0, "R9 reset mode/peri", mode_cfg | peri_cfg, 0);
    chk(dut_oe == 0 && board_rst == 0, "R9 reset oe/board_rst", {30'h0, dut_oe, board_rst}, 0);
    quiet = 1'b0;

    // R5 / R2 identification and inputs
    rd(10'h000, "R5 R2 id 0x000");
    rd(10'h001, "R5 id 0x001");
    rd(10'h002, "R5 id 0x002");
    rd(10'h003, "R5 id 0x003");
    rd(10'h006, "R5 strap low");
    rd(10'h007, "R5 strap high");
    rd(10'h008, "R5 dip switches");
    dip_sw = 16'h5A0F;
    rd(10'h008, "R5 dip switches after change");

    // R4 writable registers
    wr(10'h00E, 16'hBEEF);
    wr(10'h004, 16'h8001);
    wr(10'h005, 16'h7FFE);
    wr(10'h00B, 16'h00C3);
    wr(10'h00C, 16'h1248);
    wr(10'h00D, 16'hFEDC);
    rd(10'h00E, "R4 led readback");
    rd(10'h004, "R4 mode low readback");
    rd(10'h005, "R4 mode high readback");
    rd(10'h00B, "R4 power readback");
    rd(10'h00C, "R4 peri low readback");
    rd(10'h00D, "R4 peri high readback");

    // R5 writes to read-only ignored, R6 unmapped
    wr(10'h001, 16'h1111);
    rd(10'h001, "R5 read-only write ignored");
    wr(10'h008, 16'h2222);
    rd(10'h008, "R5 dip write ignored");
    wr(10'h009, 16'h3333);
    rd(10'h009, "R6 unmapped 0x009");
    rd(10'h100, "R6 unmapped 0x100");
    rd(10'h3FF, "R6 unmapped 0x3FF");
    rd(10'h02E, "R2 0x02E is not 0x00E");

    // R1 malformed frames have no effect
    raw_frame(20, 2'b01, 2'b01, 10'h00E, 16'h1234);
    rd(10'h00E, "R1 short preamble ignored");
    raw_frame(32, 2'b00, 2'b01, 10'h00E, 16'h4321);
    rd(10'h00E, "R1 bad start ignored");
    raw_frame(32, 2'b01, 2'b11, 10'h00E, 16'h5555);
    rd(10'h00E, "R1 opcode 11 ignored");
    raw_frame(32, 2'b01, 2'b00, 10'h00B, 16'h6666);
    rd(10'h00B, "R1 opcode 00 ignored");

    // R7 reset request
    wr(10'h00A, 16'h0001);
    rd(10'h00A, "R7 reset register clears");
    chk(pulses == 1, "R7 one pulse seen", pulses, 1);
    wr(10'h00A, 16'h0002);
    rd(10'h00A, "R7 non-one value stored");
    chk(pulses == 1, "R7 no pulse for other value", pulses, 1);

    // R8 slow region
    rd(10'h302, "R8 first read returns reset latch");
    rd(10'h302, "R8 second read serial low");
    rd(10'h300, "R8 stale after address change");
    rd(10'h300, "R8 board revision");
    rd(10'h303, "R8 stale board revision");
    rd(10'h303, "R8 serial high");
    rd(10'h301, "R8 stale serial high");
    rd(10'h301, "R8 soc revision");

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule